// File: doc/BRIEF.md
# PLL Unlock Detector with Stretch

This block decides whether a phase-locked loop is in lock by watching the phase-error pulses that a phase-frequency comparator produces. The up and down error pulses are combined with OR, and the length of each resulting pulse is measured in system-clock cycles. That length is compared with a detection window chosen by a 2-bit code. When a pulse is longer than the window, an unlock flag is raised. The flag is then held until the second 1 ms tick after the last over-window error, so it stays up for between 1 and 2 ms.

The code also selects simpler behaviours. Code 00 switches detection off, so the flag never rises. Code 01 uses a window of zero width: the combined error signal goes straight to the output with no stretching. Codes 10 and 11 select the narrow and wide windows. The design provides two views of the result. The active-high `unlock_o` drives an external status pin through an inverting, pull-low driver. `lock_bit_o` is the host-readable status bit, and it reads 0 while the loop is unlocked.

Top module: `pll_lock_monitor`

## Requirements
- R1: While reset is asserted, and after reset is released with no error input, `unlock_o` is 0 and `lock_bit_o` is 1.
- R2: With `width_sel` = 2'b00, `unlock_o` stays 0 whatever the error inputs do.
- R3: With `width_sel` = 2'b01, `unlock_o` equals `err_up | err_dn` in the same cycle, without a clock edge in between. It returns to 0 as soon as the error inputs drop.
- R4: With `width_sel` = 2'b10, an error pulse sampled high on more than WIN_NARROW consecutive rising edges (default 2) sets `unlock_o` after the edge that sees sample WIN_NARROW+1. A pulse of WIN_NARROW samples or fewer leaves it at 0.
- R5: With `width_sel` = 2'b11, the same rule as R4 applies with WIN_WIDE consecutive samples (default 4).
- R6: Once set in code 10 or 11, `unlock_o` stays 1 through the first `tick_1ms` pulse after the last over-window error. It clears on the edge that samples the second such tick.
- R7: A new over-window error restarts the stretch. Ticks seen before it do not count toward release. An over-window error and a tick in the same cycle count as a restart.
- R8: The pulse length is measured on `err_up | err_dn`. An up pulse followed by an overlapping down pulse counts as one continuous pulse.
- R9: `lock_bit_o` is always the inverse of `unlock_o`.
- R10: Moving `width_sel` to 2'b00 or 2'b01 cancels any pending stretch on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that sets the width-measurement resolution |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_up | input | 1 | Up phase-error pulse from the comparator |
| err_dn | input | 1 | Down phase-error pulse from the comparator |
| width_sel | input | 2 | Detection mode: 00 off, 01 raw, 10 narrow window, 11 wide window |
| tick_1ms | input | 1 | One-cycle pulse every 1 ms |
| unlock_o | output | 1 | Active-high unlock indication: raw or stretched |
| lock_bit_o | output | 1 | Host-readable lock status, 0 while unlocked |

## Verification
The bench builds the block with the default windows of 2 and 4 cycles, the values a 3.6 MHz clock gives. With these short windows, each threshold can be tested from both sides with pulses only a few cycles long: a 2-cycle against a 3-cycle pulse, and a 4-cycle against a 5-cycle pulse. The 1 ms tick is driven directly as a one-cycle pulse, so release, restart and a tick that coincides with an error all fit in a few dozen cycles instead of thousands.

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int WIN_NARROW = 2,
  parameter int WIN_WIDE   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_up,
  input  logic       err_dn,
  input  logic [1:0] width_sel,
  input  logic       tick_1ms,
  output logic       unlock_o,
  output logic       lock_bit_o
);
  localparam int PW_W = $clog2(WIN_WIDE + 1);

  logic            err;
  logic [PW_W-1:0] run_len;
  logic [PW_W-1:0] win;
  logic            over_evt;
  logic            held;
  logic            tick_seen;

  assign err      = err_up | err_dn;
  assign win      = width_sel[0] ? PW_W'(WIN_WIDE) : PW_W'(WIN_NARROW);
  assign over_evt = width_sel[1] & err & (run_len >= win);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            run_len <= '0;
    else if (!err)                         run_len <= '0;
    else if (run_len != PW_W'(WIN_WIDE))   run_len <= run_len + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      held      <= 1'b0;
      tick_seen <= 1'b0;
    end else if (!width_sel[1]) begin
      held      <= 1'b0;
      tick_seen <= 1'b0;
    end else if (over_evt) begin
      held      <= 1'b1;
      tick_seen <= 1'b0;
    end else if (held && tick_1ms) begin
      if (tick_seen) begin
        held      <= 1'b0;
        tick_seen <= 1'b0;
      end else begin
        tick_seen <= 1'b1;
      end
    end

  always_comb
    case (width_sel)
      2'b00:   unlock_o = 1'b0;
      2'b01:   unlock_o = err;
      default: unlock_o = held;
    endcase

  assign lock_bit_o = ~unlock_o;

  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    width_sel == 2'b00 |-> !unlock_o);

  a_r4_set_after_over: assert property (@(posedge clk) disable iff (!rst_n)
    over_evt |=> (unlock_o || !width_sel[1]));

  a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (width_sel[1] && $past(width_sel[1]) && $past(unlock_o) && !$past(tick_1ms))
      |-> unlock_o);

  a_r6_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(unlock_o) && width_sel[1] && $past(width_sel[1])) |-> $past(tick_1ms));

  a_r9_bit_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    lock_bit_o != unlock_o);
endmodule

// File: tb/pll_lock_monitor_tb_top.sv
module pll_lock_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       err_up = 1'b0;
  logic       err_dn = 1'b0;
  logic [1:0] width_sel = 2'b00;
  logic       tick_1ms = 1'b0;
  logic       unlock_o;
  logic       lock_bit_o;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  pll_lock_monitor #(.WIN_NARROW(2), .WIN_WIDE(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .err_up(err_up), .err_dn(err_dn),
    .width_sel(width_sel), .tick_1ms(tick_1ms),
    .unlock_o(unlock_o), .lock_bit_o(lock_bit_o));

  // {sel[1:0], use_dn, len[3:0], expected unlock after pulse}
  localparam logic [7:0] VEC [10] = '{
    {2'b10, 1'b0, 4'd2,  1'b0},
    {2'b10, 1'b0, 4'd3,  1'b1},
    {2'b10, 1'b1, 4'd1,  1'b0},
    {2'b10, 1'b1, 4'd6,  1'b1},
    {2'b11, 1'b0, 4'd4,  1'b0},
    {2'b11, 1'b1, 4'd5,  1'b1},
    {2'b11, 1'b0, 4'd3,  1'b0},
    {2'b00, 1'b0, 4'd10, 1'b0},
    {2'b00, 1'b1, 4'd10, 1'b0},
    {2'b01, 1'b0, 4'd10, 1'b0}
  };

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (unlock_o !== exp || lock_bit_o !== ~exp) begin
      n_bad++;
      $display("FAIL %s: unlock_o=%b lock_bit_o=%b expected unlock_o=%b lock_bit_o=%b",
               req, unlock_o, lock_bit_o, exp, ~exp);
    end
  endtask

  task automatic pulse(input logic up, input logic dn, input int len);
    @(negedge clk);
    err_up = up; err_dn = dn;
    repeat (len) @(negedge clk);
    err_up = 1'b0; err_dn = 1'b0;
    #0.5;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1ms = 1'b1;
    @(negedge clk);
    tick_1ms = 1'b0;
    #0.5;
  endtask

  task automatic clear_state();
    @(negedge clk);
    width_sel = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", 1'b0);

    for (int i = 0; i < 10; i++) begin
      clear_state();
      width_sel = VEC[i][7:6];
      pulse(!VEC[i][5], VEC[i][5], int'(VEC[i][4:1]));
      case (VEC[i][7:6])
        2'b00:   check("R2 vector", VEC[i][0]);
        2'b01:   check("R3 vector", VEC[i][0]);
        2'b10:   check("R4 vector", VEC[i][0]);
        default: check("R5 vector", VEC[i][0]);
      endcase
    end

    // R3: raw path follows input within the cycle
    clear_state();
    width_sel = 2'b01;
    err_dn = 1'b1; #0.5;
    check("R3 raw high", 1'b1);
    err_dn = 1'b0; #0.5;
    check("R3 raw low", 1'b0);

    // R6: first tick holds, second releases
    clear_state();
    width_sel = 2'b10;
    pulse(1'b1, 1'b0, 3);
    tick();
    check("R6 after first tick", 1'b1);
    repeat (3) @(negedge clk);
    check("R6 no tick held", 1'b1);
    tick();
    check("R6 after second tick", 1'b0);

    // R7: restart discards earlier tick
    clear_state();
    width_sel = 2'b11;
    pulse(1'b0, 1'b1, 5);
    tick();
    pulse(1'b1, 1'b0, 5);
    tick();
    check("R7 restarted hold", 1'b1);
    tick();
    check("R7 release after restart", 1'b0);

    // R7: over-window error coinciding with a tick counts as restart
    clear_state();
    width_sel = 2'b10;
    pulse(1'b1, 1'b0, 3);
    tick();
    @(negedge clk);
    err_up = 1'b1;
    repeat (2) @(negedge clk);
    tick_1ms = 1'b1;
    @(negedge clk);
    tick_1ms = 1'b0; err_up = 1'b0;
    #0.5;
    tick();
    check("R7 coincident tick", 1'b1);
    tick();
    check("R7 coincident release", 1'b0);

    // R8: overlapping up then down forms one pulse of 3
    clear_state();
    width_sel = 2'b10;
    @(negedge clk);
    err_up = 1'b1;
    @(negedge clk);
    err_dn = 1'b1;
    @(negedge clk);
    err_up = 1'b0;
    @(negedge clk);
    err_dn = 1'b0;
    #0.5;
    check("R8 combined pulse", 1'b1);

    // R10: leaving the windowed modes cancels the stretch
    @(negedge clk);
    width_sel = 2'b00;
    @(negedge clk);
    width_sel = 2'b10;
    #0.5;
    check("R10 cancelled", 1'b0);

    // R1: reset in the middle of a stretch
    pulse(1'b1, 1'b0, 4);
    check("R1 pre-reset set", 1'b1);
    rst_n = 1'b0; #0.5;
    check("R1 reset clears", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule